// File: doc/BRIEF.md
# AHB-Lite Single-Transfer Bus Master

This block is a bus master that turns one-shot user read and write requests into 32-bit AHB-Lite single transfers. The user raises a request strobe with a write flag, an address and (for writes) a data word. The master then runs a one-cycle address phase followed by a data phase. It stretches the data phase for as many wait states as the slave inserts, and it signals completion with a one-cycle done pulse, read data and an error flag.

Only one transfer is in flight at a time. While the master is busy, any new request is ignored. The user side therefore waits for the busy flag to fall before it issues the next request. Bursts, locked transfers, protection signalling and arbitration are not part of this block.

Top module: `ahbl_single_master`

## Requirements
- R1: While the synchronous active-low reset is sampled low, the block returns to idle. On the cycle after, `htrans` is IDLE (2'b00), `usr_busy` is 0, `usr_done` is 0 and `usr_err` is 0.
- R2: A request sampled while idle starts an address phase on the next cycle. In that cycle `htrans` is NONSEQ (2'b10), `haddr` and `hwrite` carry the request, `hsize` is 3'b010 for a 32-bit bus, `hburst` is 3'b000 and `usr_busy` is 1.
- R3: With `hready` high, the address phase lasts exactly one cycle, and `htrans` is IDLE in the data phase that follows. While `hready` is low during an address phase, `htrans`, `haddr` and `hwrite` hold their values.
- R4: Each cycle in which `hready` is sampled low during the data phase adds one more data-phase cycle. During those cycles `usr_done` stays 0 and `usr_busy` stays 1.
- R5: For a write, `hwdata` equals the request's write data in every data-phase cycle, including every wait cycle.
- R6: For a read, `usr_rdata` takes the `hrdata` value sampled in the data-phase cycle where `hready` is high. Values presented during wait cycles have no effect.
- R7: The cycle after the data phase completes, `usr_done` is 1 for exactly one cycle and `usr_busy` is 0.
- R8: If `hresp` is 1 (ERROR) on the completing cycle, `usr_err` is 1 alongside `usr_done`. It stays 1 until the next request is accepted. With the default setting, a read that ends in ERROR leaves `usr_rdata` unchanged. `hresp` 0 means OKAY and gives `usr_err` 0.
- R9: A request raised while `usr_busy` is 1 is ignored. The bus address does not change, and no new address phase follows the current transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Synchronous reset, active low |
| usr_req | input | 1 | Request strobe, taken when idle |
| usr_wr | input | 1 | 1 = write, 0 = read |
| usr_addr | input | 32 | Transfer address |
| usr_wdata | input | 32 | Write data |
| usr_busy | output | 1 | Transfer in progress |
| usr_done | output | 1 | One-cycle completion pulse |
| usr_rdata | output | 32 | Last successful read data |
| usr_err | output | 1 | Last transfer got ERROR |
| haddr | output | 32 | Bus address |
| hwrite | output | 1 | Bus direction |
| htrans | output | 2 | Transfer type (IDLE/NONSEQ) |
| hsize | output | 3 | Transfer size |
| hburst | output | 3 | Burst type, always single |
| hwdata | output | 32 | Bus write data |
| hready | input | 1 | Slave ready |
| hresp | input | 1 | Slave response, 1 = ERROR |
| hrdata | input | 32 | Bus read data |

## Verification
A stuck or mis-stepped phase state appears on `htrans` within one cycle. Examples are a NONSEQ that persists after `hready`, or an IDLE in place of the address phase. A state that ignores `hready` makes `usr_done` rise during a wait cycle. A held-data register that reloads at the wrong moment changes `hwdata` in the middle of a wait sequence, or changes `haddr` when a request arrives while busy. Both are visible at the next edge. A misplaced capture shows up as wait-cycle data or ERROR-phase data in `usr_rdata` on the done cycle.

// File: rtl/ahbl_sm_pkg.sv
package ahbl_sm_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} sm_state_e;
   localparam logic [1:0] TR_IDLE      = 2'b00;
   localparam logic [1:0] TR_NONSEQ    = 2'b10;
   localparam logic [2:0] BURST_SINGLE = 3'b000;
endpackage

// File: rtl/ahbl_sm_ctrl.sv
module ahbl_sm_ctrl
   import ahbl_sm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic hready,
   output logic accept,
   output logic addr_ph,
   output logic data_ph,
   output logic complete,
   output logic busy,
   output logic done
);
   sm_state_e st_q, st_d;

   assign accept   = (st_q == ST_IDLE) && req;
   assign addr_ph  = (st_q == ST_ADDR);
   assign data_ph  = (st_q == ST_DATA);
   assign complete = data_ph && hready;
   assign busy     = (st_q != ST_IDLE);

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: if (req)    st_d = ST_ADDR;
         ST_ADDR: if (hready) st_d = ST_DATA;
         ST_DATA: if (hready) st_d = ST_IDLE;
         default:             st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         done <= 1'b0;
      end else begin
         st_q <= st_d;
         done <= complete;
      end
   end

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R4
   wait_extends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_ph && !hready) |=> (data_ph && !done));
endmodule

// File: rtl/ahbl_sm_hold.sv
module ahbl_sm_hold #(
   parameter int  AW           = 32,
   parameter int  DW           = 32,
   parameter bit  ERR_ZERO_RD  = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          complete,
   input  logic          wr_in,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] wdata_in,
   input  logic          hresp,
   input  logic [DW-1:0] hrdata,
   output logic [AW-1:0] haddr,
   output logic          hwrite,
   output logic [DW-1:0] hwdata,
   output logic [DW-1:0] rdata,
   output logic          err
);
   logic rd_ok, rd_bad;
   assign rd_ok  = complete && !hwrite && !hresp;
   assign rd_bad = complete && !hwrite && hresp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         haddr  <= '0;
         hwrite <= 1'b0;
         hwdata <= '0;
         err    <= 1'b0;
      end else if (accept) begin
         haddr  <= addr_in;
         hwrite <= wr_in;
         hwdata <= wdata_in;
         err    <= 1'b0;
      end else if (complete) begin
         err    <= hresp;
      end
   end

   generate
      if (ERR_ZERO_RD) begin : g_rd_zero
         always_ff @(posedge clk) begin
            if (!rst_n)      rdata <= '0;
            else if (rd_ok)  rdata <= hrdata;
            else if (rd_bad) rdata <= '0;
         end
      end else begin : g_rd_keep
         always_ff @(posedge clk) begin
            if (!rst_n)     rdata <= '0;
            else if (rd_ok) rdata <= hrdata;
         end
      end
   endgenerate

   // R5
   wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(hwdata));
   // R6
   rdata_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !complete |=> $stable(rdata));
endmodule

// File: rtl/ahbl_single_master.sv
module ahbl_single_master
   import ahbl_sm_pkg::*;
#(
   parameter int AW          = 32,
   parameter int DW          = 32,
   parameter bit ERR_ZERO_RD = 1'b0
) (
   input  logic          hclk,
   input  logic          hresetn,
   input  logic          usr_req,
   input  logic          usr_wr,
   input  logic [AW-1:0] usr_addr,
   input  logic [DW-1:0] usr_wdata,
   output logic          usr_busy,
   output logic          usr_done,
   output logic [DW-1:0] usr_rdata,
   output logic          usr_err,
   output logic [AW-1:0] haddr,
   output logic          hwrite,
   output logic [1:0]    htrans,
   output logic [2:0]    hsize,
   output logic [2:0]    hburst,
   output logic [DW-1:0] hwdata,
   input  logic          hready,
   input  logic          hresp,
   input  logic [DW-1:0] hrdata
);
   localparam int          BYTES     = DW / 8;
   localparam logic [2:0]  SIZE_CODE = 3'($clog2(BYTES));

   generate
      if (DW < 8 || DW > 1024 || (DW & (DW - 1)) != 0) begin : g_bad_dw
         $error("data width must be a power of two from 8 to 1024");
      end
      if (AW < 1 || AW > 64) begin : g_bad_aw
         $error("address width must be 1 to 64");
      end
   endgenerate

   logic accept, addr_ph, data_ph, complete;

   ahbl_sm_ctrl u_ctrl (
      .clk      (hclk),
      .rst_n    (hresetn),
      .req      (usr_req),
      .hready   (hready),
      .accept   (accept),
      .addr_ph  (addr_ph),
      .data_ph  (data_ph),
      .complete (complete),
      .busy     (usr_busy),
      .done     (usr_done)
   );

   ahbl_sm_hold #(.AW(AW), .DW(DW), .ERR_ZERO_RD(ERR_ZERO_RD)) u_hold (
      .clk      (hclk),
      .rst_n    (hresetn),
      .accept   (accept),
      .complete (complete),
      .wr_in    (usr_wr),
      .addr_in  (usr_addr),
      .wdata_in (usr_wdata),
      .hresp    (hresp),
      .hrdata   (hrdata),
      .haddr    (haddr),
      .hwrite   (hwrite),
      .hwdata   (hwdata),
      .rdata    (usr_rdata),
      .err      (usr_err)
   );

   assign htrans = addr_ph ? TR_NONSEQ : TR_IDLE;
   assign hsize  = SIZE_CODE;
   assign hburst = BURST_SINGLE;

   // R3
   addr_hold_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      (htrans == TR_NONSEQ && !hready) |=>
         (htrans == TR_NONSEQ && $stable(haddr) && $stable(hwrite)));
   // R3
   single_beat_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      (htrans == TR_NONSEQ && hready) |=> (htrans == TR_IDLE));
   // R9
   busy_ignore_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      usr_busy |=> $stable(haddr));
   // R8
   err_with_done_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      $rose(usr_err) |-> usr_done);
   // R2
   start_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      (!usr_busy && usr_req) |=> (htrans == TR_NONSEQ && usr_busy));
endmodule

// File: tb/ahbl_single_master_tb.sv
module ahbl_single_master_tb;
   logic        hclk = 1'b0;
   logic        hresetn;
   logic        usr_req, usr_wr;
   logic [31:0] usr_addr, usr_wdata;
   logic        usr_busy, usr_done, usr_err;
   logic [31:0] usr_rdata;
   logic [31:0] haddr, hwdata, hrdata;
   logic        hwrite, hready, hresp;
   logic [1:0]  htrans;
   logic [2:0]  hsize, hburst;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] exp_rdata = 32'h0;
   bit finished = 1'b0;

   always #4 hclk = ~hclk;

   ahbl_single_master u_dut (
      .hclk(hclk), .hresetn(hresetn),
      .usr_req(usr_req), .usr_wr(usr_wr), .usr_addr(usr_addr),
      .usr_wdata(usr_wdata), .usr_busy(usr_busy), .usr_done(usr_done),
      .usr_rdata(usr_rdata), .usr_err(usr_err),
      .haddr(haddr), .hwrite(hwrite), .htrans(htrans), .hsize(hsize),
      .hburst(hburst), .hwdata(hwdata), .hready(hready), .hresp(hresp),
      .hrdata(hrdata)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic t_reset();
      hresetn = 1'b0; usr_req = 1'b0; usr_wr = 1'b0; usr_addr = '0;
      usr_wdata = '0; hready = 1'b1; hresp = 1'b0; hrdata = '0;
      repeat (3) @(negedge hclk);
      chk("R1 htrans", 64'(htrans), 64'h0);
      chk("R1 busy", 64'(usr_busy), 64'h0);
      chk("R1 done", 64'(usr_done), 64'h0);
      chk("R1 err", 64'(usr_err), 64'h0);
      hresetn = 1'b1;
      @(negedge hclk);
      exp_rdata = 32'h0;
   endtask

   // one transfer; waits = data-phase wait cycles, aw = address-phase waits
   task automatic t_xfer(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                         input int aw, input int waits, input bit e,
                         input logic [31:0] bus_rd, input bit poke);
      usr_req = 1'b1; usr_wr = wr; usr_addr = a; usr_wdata = wd;
      hready = 1'b1; hresp = 1'b0;
      @(negedge hclk);
      usr_req = 1'b0;
      chk("R2 htrans nonseq", 64'(htrans), 64'h2);
      chk("R2 haddr", 64'(haddr), 64'(a));
      chk("R2 hwrite", 64'(hwrite), 64'(wr));
      chk("R2 hsize", 64'(hsize), 64'h2);
      chk("R2 hburst", 64'(hburst), 64'h0);
      chk("R2 busy", 64'(usr_busy), 64'h1);
      chk("R8 err cleared on accept", 64'(usr_err), 64'h0);
      for (int i = 0; i < aw; i++) begin
         hready = 1'b0;
         @(negedge hclk);
         chk("R3 nonseq held", 64'(htrans), 64'h2);
         chk("R3 haddr held", 64'(haddr), 64'(a));
         chk("R3 hwrite held", 64'(hwrite), 64'(wr));
      end
      hready = 1'b1;
      @(negedge hclk);
      chk("R3 data phase idle", 64'(htrans), 64'h0);
      for (int i = 0; i < waits; i++) begin
         hready = 1'b0;
         hresp = e && (i == waits - 1);
         hrdata = 32'hDEAD_0000 + 32'(i);
         if (poke) begin
            usr_req = 1'b1; usr_addr = ~a; usr_wr = ~wr;
         end
         @(negedge hclk);
         usr_req = 1'b0;
         chk("R4 done low in wait", 64'(usr_done), 64'h0);
         chk("R4 busy in wait", 64'(usr_busy), 64'h1);
         if (wr) chk("R5 hwdata in wait", 64'(hwdata), 64'(wd));
         if (poke) chk("R9 haddr ignores busy req", 64'(haddr), 64'(a));
      end
      hready = 1'b1; hresp = e; hrdata = bus_rd;
      if (wr) chk("R5 hwdata last cycle", 64'(hwdata), 64'(wd));
      @(negedge hclk);
      hresp = 1'b0; hrdata = 32'h5A5A_5A5A;
      if (!wr && !e) exp_rdata = bus_rd;
      chk("R7 done", 64'(usr_done), 64'h1);
      chk("R7 busy low", 64'(usr_busy), 64'h0);
      chk("R8 err", 64'(usr_err), 64'(e));
      chk("R6 rdata", 64'(usr_rdata), 64'(exp_rdata));
      @(negedge hclk);
      chk("R7 done single cycle", 64'(usr_done), 64'h0);
      chk("R8 err held", 64'(usr_err), 64'(e));
      if (poke) begin
         chk("R9 no new address phase", 64'(htrans), 64'h0);
         chk("R9 haddr unchanged", 64'(haddr), 64'(a));
      end
   endtask

   initial begin
      repeat (20000) @(posedge hclk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_xfer(1'b1, 32'h0000_1000, 32'hCAFE_F00D, 0, 0, 1'b0, 32'h0, 1'b0);
      t_xfer(1'b0, 32'h0000_2004, 32'h0, 0, 0, 1'b0, 32'h1234_5678, 1'b0);
      t_xfer(1'b1, 32'h0000_3008, 32'hA5A5_0F0F, 0, 3, 1'b0, 32'h0, 1'b0);
      t_xfer(1'b0, 32'h0000_400C, 32'h0, 0, 4, 1'b0, 32'h8765_4321, 1'b0);
      t_xfer(1'b0, 32'h0000_5010, 32'h0, 2, 1, 1'b0, 32'h0BAD_BEEF, 1'b0);
      t_xfer(1'b0, 32'h0000_6014, 32'h0, 0, 1, 1'b1, 32'hFFFF_FFFF, 1'b0);
      t_xfer(1'b1, 32'h0000_7018, 32'h1111_2222, 0, 2, 1'b1, 32'h0, 1'b0);
      t_xfer(1'b1, 32'h0000_801C, 32'h3333_4444, 0, 3, 1'b0, 32'h0, 1'b1);
      t_xfer(1'b0, 32'h0000_9020, 32'h0, 1, 2, 1'b0, 32'h7777_0001, 1'b1);
      t_reset();
      chk("R1 rdata after reset", 64'(usr_rdata), 64'h0);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule